// File: doc/BRIEF.md
# Wrap-Around Call-Path Recorder

This block keeps a record of a program's open calls in a small ring of slots with a top pointer. A retired CALL moves the top pointer forward one place, wrapping at the ring size, and stores the branch's source and target address in the slot the pointer now names. A retired RET erases the slot under the top pointer and then moves the pointer back one place. A slot that holds zero in both address fields is empty. A taken branch can never come from or go to address zero, so zero is a safe end marker.

A call path deeper than the ring overwrites only one slot at a time, at the top. The oldest frames still held in the other slots stay where they are. A readout walker starts at the top pointer and steps backwards, wrapping around the ring. It returns every occupied slot as a valid/ready stream and stops at the first empty slot, or after it has visited every slot. Its output follows these back-pressure rules:
- When the sink holds ready low, the walker keeps the same slot and data on the outputs.
- The walker moves to the next slot only after a handshake.

A context port handles the save and restore of a context:
- A load pulse empties every slot and sets the top pointer.
- Individual writes then put back the saved records.
- Any slot not written by the restore stays empty.
- A plain read port shows any slot and the top pointer, for saving.

The event port has no back-pressure, because retirement cannot be stalled. A CALL and a RET in the same cycle are split in order: the CALL runs first and the RET runs one cycle later.

Top module: `callstack_rec`

## Requirements
- R1: After reset the top pointer is 0, every slot reads zero on the read port, `rec_valid_o` is 0 and `walk_done_o` is 0.
- R2: A CALL that is executed sets the top pointer to (top+1) modulo DEPTH and writes `ev_from_i`/`ev_to_i` into that slot. Every other slot is left unchanged.
- R3: A RET that is executed clears the slot at the top pointer to zero and then sets the top pointer to (top-1) modulo DEPTH. This also happens when that slot is already zero: the pointer still steps back and the slot stays zero.
- R4: A `clr_i` cycle has these effects:
  - It empties every slot and sets the top pointer to 0.
  - It stops a walk in progress, so that `walk_done_o` is 0 and `rec_valid_o` is 0.
  - It discards any deferred event, along with the events presented in that cycle.
- R5: Events execute one per cycle and in program order:
  - A deferred event goes first.
  - Then a CALL, then a RET.
  - The second event of a cycle is deferred to the next cycle.
  - A third event in the same cycle (a deferred event plus a CALL and a RET) has its RET dropped.
- R6: After more than DEPTH calls, every slot still holds the most recent record written to it. Frames from before the wrap stay readable.
- R7: On `walk_start_i` while idle, the walker does the following:
  - It presents the slot at the top pointer. `rec_idx_o` gives the slot position.
  - After each handshake it moves to the previous slot, modulo DEPTH.
  - `rec_valid_o` is high only for occupied slots.
  - On reaching an empty slot it ends. In the cycle after that, `walk_done_o` rises and `walk_count_o` holds the number of records delivered.
- R8: If no slot is empty, the walk ends after DEPTH handshakes. `walk_count_o` then reads DEPTH.
- R9: While `rec_valid_o` is high and `rec_ready_i` is low, `rec_valid_o`, `rec_idx_o`, `rec_from_o` and `rec_to_o` hold their values.
- R10: A `ctx_load_i` cycle empties every slot, stops any walk and loads the top pointer from `ctx_tos_i`. It also discards the events presented in that cycle.
- R11: A `ctx_we_i` cycle writes `ctx_from_i`/`ctx_to_i` into slot `ctx_idx_i` and does not move the top pointer. It discards the events presented in that cycle. If `clr_i` or `ctx_load_i` is active in the same cycle, that clear wins.
- R12: `rd_from_o`/`rd_to_o` show slot `rd_idx_i` combinationally, and `tos_o` shows the top pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| clr_i | input | 1 | Synchronous clear on arm or reschedule |
| ev_call_i | input | 1 | A CALL retired this cycle |
| ev_ret_i | input | 1 | A RET retired this cycle |
| ev_from_i | input | AW | Branch source address of the CALL |
| ev_to_i | input | AW | Branch target address of the CALL |
| walk_start_i | input | 1 | Start a readout walk (ignored while busy) |
| rec_valid_o | output | 1 | Walker record valid |
| rec_ready_i | input | 1 | Walker record accepted |
| rec_idx_o | output | IDXW | Slot position of the record |
| rec_from_o | output | AW | Source address of the record |
| rec_to_o | output | AW | Target address of the record |
| walk_count_o | output | CW | Records delivered in the current or last walk |
| walk_done_o | output | 1 | Walk finished |
| ctx_load_i | input | 1 | Restore start: empty all slots, load pointer |
| ctx_tos_i | input | IDXW | Top pointer value to restore |
| ctx_we_i | input | 1 | Restore write of one slot |
| ctx_idx_i | input | IDXW | Slot position for the restore write |
| ctx_from_i | input | AW | Saved source address |
| ctx_to_i | input | AW | Saved target address |
| rd_idx_i | input | IDXW | Read-port slot select |
| rd_from_o | output | AW | Read-port source address |
| rd_to_o | output | AW | Read-port target address |
| tos_o | output | IDXW | Current top pointer |

## Verification
The bench builds the recorder with DEPTH=8 and AW=16, whereas the defaults are 32 and 32. With eight slots, a run of eleven calls wraps the pointer in a few cycles, which covers overflow survival and the full-ring walk that ends on its slot count. The same short ring lets a RET on an empty slot wrap the pointer backwards from 0 to 7. It also keeps full-state comparisons through the read port short, so every directed scenario can compare the whole ring against the bench's own model.

// File: rtl/callstack_pkg.sv
package callstack_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_CALL = 2'd1,
    OP_RET  = 2'd2
  } op_e;
endpackage

// File: rtl/cs_event_seq.sv
// Orders retirement events: one executes per cycle, the next is held back.
module cs_event_seq
  import callstack_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          block_i,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic [AW-1:0] from_i,
  input  logic [AW-1:0] to_i,
  output op_e           op_o,
  output logic [AW-1:0] op_from_o,
  output logic [AW-1:0] op_to_o,
  output logic          pend_o
);
  logic          pend_q, pend_call_q;
  logic [AW-1:0] pend_from_q, pend_to_q;
  logic          nx_v, nx_call;

  always_comb begin
    op_o      = OP_NONE;
    op_from_o = pend_from_q;
    op_to_o   = pend_to_q;
    nx_v      = 1'b0;
    nx_call   = 1'b0;
    if (!block_i) begin
      if (pend_q) begin
        op_o = pend_call_q ? OP_CALL : OP_RET;
        if (call_i) begin
          nx_v    = 1'b1;
          nx_call = 1'b1;
        end else if (ret_i) begin
          nx_v = 1'b1;
        end
      end else begin
        op_from_o = from_i;
        op_to_o   = to_i;
        if (call_i) begin
          op_o = OP_CALL;
          nx_v = ret_i;
        end else if (ret_i) begin
          op_o = OP_RET;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_call_q <= 1'b0;
      pend_from_q <= '0;
      pend_to_q   <= '0;
    end else begin
      pend_q      <= nx_v;
      pend_call_q <= nx_call;
      pend_from_q <= from_i;
      pend_to_q   <= to_i;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/cs_tos_ctrl.sv
// Top-of-stack pointer with wrap in both directions.
module cs_tos_ctrl
  import callstack_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            load_i,
  input  logic [IDXW-1:0] load_val_i,
  input  op_e             op_i,
  output logic [IDXW-1:0] tos_o,
  output logic [IDXW-1:0] tos_inc_o
);
  localparam logic [IDXW-1:0] LAST = IDXW'(DEPTH - 1);
  logic [IDXW-1:0] tos_q, tos_dec;

  assign tos_inc_o = (tos_q == LAST) ? '0 : tos_q + 1'b1;
  assign tos_dec   = (tos_q == '0) ? LAST : tos_q - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tos_q <= '0;
    else if (clr_i)            tos_q <= '0;
    else if (load_i)           tos_q <= load_val_i;
    else if (op_i == OP_CALL)  tos_q <= tos_inc_o;
    else if (op_i == OP_RET)   tos_q <= tos_dec;
  end

  assign tos_o = tos_q;
endmodule

// File: rtl/cs_slot_bank.sv
// Record storage: one write port, bulk clear, two read ports.
module cs_slot_bank #(
  parameter int DEPTH = 32,
  parameter int AW    = 32,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_all_i,
  input  logic            we_i,
  input  logic [IDXW-1:0] widx_i,
  input  logic [AW-1:0]   wfrom_i,
  input  logic [AW-1:0]   wto_i,
  input  logic [IDXW-1:0] ra_idx_i,
  output logic [AW-1:0]   ra_from_o,
  output logic [AW-1:0]   ra_to_o,
  input  logic [IDXW-1:0] rb_idx_i,
  output logic [AW-1:0]   rb_from_o,
  output logic [AW-1:0]   rb_to_o
);
  localparam logic [IDXW-1:0] LAST = IDXW'(DEPTH - 1);
  logic [AW-1:0] slot_from [DEPTH];
  logic [AW-1:0] slot_to   [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_from[g] <= '0;
        slot_to[g]   <= '0;
      end else if (clr_all_i) begin
        slot_from[g] <= '0;
        slot_to[g]   <= '0;
      end else if (we_i && widx_i == IDXW'(g)) begin
        slot_from[g] <= wfrom_i;
        slot_to[g]   <= wto_i;
      end
    end
  end

  always_comb begin
    ra_from_o = '0;
    ra_to_o   = '0;
    rb_from_o = '0;
    rb_to_o   = '0;
    if (ra_idx_i <= LAST) begin
      ra_from_o = slot_from[ra_idx_i];
      ra_to_o   = slot_to[ra_idx_i];
    end
    if (rb_idx_i <= LAST) begin
      rb_from_o = slot_from[rb_idx_i];
      rb_to_o   = slot_to[rb_idx_i];
    end
  end
endmodule

// File: rtl/cs_walker.sv
// Backward zero-terminated readout as a valid/ready stream.
module cs_walker #(
  parameter int DEPTH = 32,
  parameter int AW    = 32,
  localparam int IDXW = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            abort_i,
  input  logic            start_i,
  input  logic [IDXW-1:0] tos_i,
  output logic [IDXW-1:0] cur_o,
  input  logic [AW-1:0]   ent_from_i,
  input  logic [AW-1:0]   ent_to_i,
  output logic            valid_o,
  input  logic            ready_i,
  output logic [IDXW-1:0] idx_o,
  output logic [AW-1:0]   from_o,
  output logic [AW-1:0]   to_o,
  output logic [CW-1:0]   count_o,
  output logic            done_o
);
  localparam logic [IDXW-1:0] LAST    = IDXW'(DEPTH - 1);
  localparam logic [CW-1:0]   CNT_END = CW'(DEPTH - 1);
  logic            busy_q, done_q, ent_ok;
  logic [IDXW-1:0] cur_q;
  logic [CW-1:0]   cnt_q;

  assign ent_ok  = (|ent_from_i) || (|ent_to_i);
  assign valid_o = busy_q && ent_ok;
  assign idx_o   = cur_q;
  assign cur_o   = cur_q;
  assign from_o  = ent_from_i;
  assign to_o    = ent_to_i;
  assign count_o = cnt_q;
  assign done_o  = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cur_q  <= '0;
      cnt_q  <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
        cur_q  <= tos_i;
        cnt_q  <= '0;
      end
    end else if (!ent_ok) begin
      busy_q <= 1'b0;
      done_q <= 1'b1;
    end else if (ready_i) begin
      cnt_q <= cnt_q + 1'b1;
      cur_q <= (cur_q == '0) ? LAST : cur_q - 1'b1;
      if (cnt_q == CNT_END) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/callstack_rec.sv
module callstack_rec
  import callstack_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW    = 32,
  localparam int IDXW = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            ev_call_i,
  input  logic            ev_ret_i,
  input  logic [AW-1:0]   ev_from_i,
  input  logic [AW-1:0]   ev_to_i,
  input  logic            walk_start_i,
  output logic            rec_valid_o,
  input  logic            rec_ready_i,
  output logic [IDXW-1:0] rec_idx_o,
  output logic [AW-1:0]   rec_from_o,
  output logic [AW-1:0]   rec_to_o,
  output logic [CW-1:0]   walk_count_o,
  output logic            walk_done_o,
  input  logic            ctx_load_i,
  input  logic [IDXW-1:0] ctx_tos_i,
  input  logic            ctx_we_i,
  input  logic [IDXW-1:0] ctx_idx_i,
  input  logic [AW-1:0]   ctx_from_i,
  input  logic [AW-1:0]   ctx_to_i,
  input  logic [IDXW-1:0] rd_idx_i,
  output logic [AW-1:0]   rd_from_o,
  output logic [AW-1:0]   rd_to_o,
  output logic [IDXW-1:0] tos_o
);
  op_e             op_w;
  logic            pend_w, block_w, clr_all_w, we_w;
  logic [AW-1:0]   op_from_w, op_to_w, wfrom_w, wto_w, wk_from_w, wk_to_w;
  logic [IDXW-1:0] tos_w, tos_inc_w, widx_w, wk_cur_w;

  assign block_w   = clr_i | ctx_load_i | ctx_we_i;
  assign clr_all_w = clr_i | ctx_load_i;

  cs_event_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .block_i(block_w),
    .call_i(ev_call_i), .ret_i(ev_ret_i), .from_i(ev_from_i), .to_i(ev_to_i),
    .op_o(op_w), .op_from_o(op_from_w), .op_to_o(op_to_w), .pend_o(pend_w)
  );

  cs_tos_ctrl #(.DEPTH(DEPTH)) u_tos (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .load_i(ctx_load_i),
    .load_val_i(ctx_tos_i), .op_i(op_w), .tos_o(tos_w), .tos_inc_o(tos_inc_w)
  );

  always_comb begin
    we_w    = 1'b1;
    widx_w  = tos_w;
    wfrom_w = '0;
    wto_w   = '0;
    if (ctx_we_i) begin
      widx_w  = ctx_idx_i;
      wfrom_w = ctx_from_i;
      wto_w   = ctx_to_i;
    end else if (op_w == OP_CALL) begin
      widx_w  = tos_inc_w;
      wfrom_w = op_from_w;
      wto_w   = op_to_w;
    end else if (op_w != OP_RET) begin
      we_w = 1'b0;
    end
  end

  cs_slot_bank #(.DEPTH(DEPTH), .AW(AW)) u_bank (
    .clk(clk), .rst_n(rst_n), .clr_all_i(clr_all_w),
    .we_i(we_w), .widx_i(widx_w), .wfrom_i(wfrom_w), .wto_i(wto_w),
    .ra_idx_i(wk_cur_w), .ra_from_o(wk_from_w), .ra_to_o(wk_to_w),
    .rb_idx_i(rd_idx_i), .rb_from_o(rd_from_o), .rb_to_o(rd_to_o)
  );

  cs_walker #(.DEPTH(DEPTH), .AW(AW)) u_walk (
    .clk(clk), .rst_n(rst_n), .abort_i(clr_all_w), .start_i(walk_start_i),
    .tos_i(tos_w), .cur_o(wk_cur_w), .ent_from_i(wk_from_w), .ent_to_i(wk_to_w),
    .valid_o(rec_valid_o), .ready_i(rec_ready_i), .idx_o(rec_idx_o),
    .from_o(rec_from_o), .to_o(rec_to_o), .count_o(walk_count_o),
    .done_o(walk_done_o)
  );

  assign tos_o = tos_w;
endmodule

// File: rtl/cs_checker.sv
module cs_checker
  import callstack_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW    = 32,
  localparam int IDXW = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clr_i,
  input logic            ev_call_i,
  input logic            ev_ret_i,
  input logic            ctx_load_i,
  input logic            ctx_we_i,
  input logic [IDXW-1:0] ctx_tos_i,
  input logic            rec_valid_o,
  input logic            rec_ready_i,
  input logic [IDXW-1:0] rec_idx_o,
  input logic [AW-1:0]   rec_from_o,
  input logic [AW-1:0]   rec_to_o,
  input logic [CW-1:0]   walk_count_o,
  input logic            walk_done_o,
  input logic [AW-1:0]   rd_from_o,
  input logic [AW-1:0]   rd_to_o,
  input logic [IDXW-1:0] tos_o,
  input op_e             op_w,
  input logic            pend_w
);
  function automatic logic [IDXW-1:0] wrap_inc(input logic [IDXW-1:0] v);
    return (v == IDXW'(DEPTH - 1)) ? '0 : v + 1'b1;
  endfunction
  function automatic logic [IDXW-1:0] wrap_dec(input logic [IDXW-1:0] v);
    return (v == '0) ? IDXW'(DEPTH - 1) : v - 1'b1;
  endfunction

  assert_call_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_w == OP_CALL) |-> tos_o == wrap_inc($past(tos_o)));

  assert_ret_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_w == OP_RET) |-> tos_o == wrap_dec($past(tos_o)));

  assert_clear_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_i) |-> (tos_o == '0 && rd_from_o == '0 && rd_to_o == '0 && !walk_done_o));

  assert_defer_ret_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_call_i && ev_ret_i && !clr_i && !ctx_load_i && !ctx_we_i && !pend_w) |=> pend_w);

  assert_pend_runs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_w && !clr_i && !ctx_load_i && !ctx_we_i) |-> op_w != OP_NONE);

  assert_valid_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid_o |-> (rec_from_o != '0 || rec_to_o != '0));

  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done_o |-> !rec_valid_o);

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    walk_count_o <= CW'(DEPTH));

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid_o && !rec_ready_i && !clr_i && !ctx_load_i && !ctx_we_i && op_w == OP_NONE)
    |=> (rec_valid_o && $stable(rec_idx_o) && $stable(rec_from_o) && $stable(rec_to_o)));

  assert_load_tos_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctx_load_i && !clr_i) |-> (tos_o == $past(ctx_tos_i) && rd_from_o == '0 && rd_to_o == '0));
endmodule

bind callstack_rec cs_checker #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .ev_call_i(ev_call_i), .ev_ret_i(ev_ret_i),
  .ctx_load_i(ctx_load_i), .ctx_we_i(ctx_we_i), .ctx_tos_i(ctx_tos_i),
  .rec_valid_o(rec_valid_o), .rec_ready_i(rec_ready_i), .rec_idx_o(rec_idx_o),
  .rec_from_o(rec_from_o), .rec_to_o(rec_to_o), .walk_count_o(walk_count_o),
  .walk_done_o(walk_done_o), .rd_from_o(rd_from_o), .rd_to_o(rd_to_o),
  .tos_o(tos_o), .op_w(op_w), .pend_w(pend_w)
);

// File: tb/callstack_rec_test.sv
module callstack_rec_test;
  localparam int D    = 8;
  localparam int AW   = 16;
  localparam int IDXW = $clog2(D);
  localparam int CW   = $clog2(D + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic clr_i = 0, ev_call_i = 0, ev_ret_i = 0, walk_start_i = 0, rec_ready_i = 1;
  logic ctx_load_i = 0, ctx_we_i = 0;
  logic [AW-1:0] ev_from_i = '0, ev_to_i = '0, ctx_from_i = '0, ctx_to_i = '0;
  logic [IDXW-1:0] ctx_tos_i = '0, ctx_idx_i = '0, rd_idx_i = '0;
  logic rec_valid_o, walk_done_o;
  logic [IDXW-1:0] rec_idx_o, tos_o;
  logic [AW-1:0] rec_from_o, rec_to_o, rd_from_o, rd_to_o;
  logic [CW-1:0] walk_count_o;

  int n_chk = 0, n_err = 0;
  int mtos;
  int mf [D];
  int mt [D];

  always #5 clk = ~clk;

  callstack_rec #(.DEPTH(D), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .ev_call_i(ev_call_i), .ev_ret_i(ev_ret_i),
    .ev_from_i(ev_from_i), .ev_to_i(ev_to_i), .walk_start_i(walk_start_i),
    .rec_valid_o(rec_valid_o), .rec_ready_i(rec_ready_i), .rec_idx_o(rec_idx_o),
    .rec_from_o(rec_from_o), .rec_to_o(rec_to_o), .walk_count_o(walk_count_o),
    .walk_done_o(walk_done_o), .ctx_load_i(ctx_load_i), .ctx_tos_i(ctx_tos_i),
    .ctx_we_i(ctx_we_i), .ctx_idx_i(ctx_idx_i), .ctx_from_i(ctx_from_i),
    .ctx_to_i(ctx_to_i), .rd_idx_i(rd_idx_i), .rd_from_o(rd_from_o),
    .rd_to_o(rd_to_o), .tos_o(tos_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int inc(input int v); return (v == D - 1) ? 0 : v + 1; endfunction
  function automatic int dec(input int v); return (v == 0) ? D - 1 : v - 1; endfunction

  // Bench model of the ring.
  task automatic m_call(input int f, input int t);
    mtos = inc(mtos); mf[mtos] = f; mt[mtos] = t;
  endtask
  task automatic m_ret();
    mf[mtos] = 0; mt[mtos] = 0; mtos = dec(mtos);
  endtask
  task automatic m_clear(input int t);
    for (int i = 0; i < D; i++) begin mf[i] = 0; mt[i] = 0; end
    mtos = t;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic ev(input bit c, input bit r, input int f, input int t);
    ev_call_i = c; ev_ret_i = r; ev_from_i = AW'(f); ev_to_i = AW'(t);
    step();
    ev_call_i = 0; ev_ret_i = 0;
  endtask

  // Compare whole ring and pointer via read port (R12).
  task automatic check_state(input string req);
    chk(int'(tos_o) == mtos, req, int'(tos_o), mtos);
    for (int i = 0; i < D; i++) begin
      rd_idx_i = IDXW'(i); #1;
      chk(int'(rd_from_o) == mf[i] && int'(rd_to_o) == mt[i], req,
          int'({rd_from_o, rd_to_o}), (mf[i] << AW) | mt[i]);
    end
  endtask

  task automatic run_walk(input string req, input bit stall);
    int exp_idx [D];
    int n = 0, c = mtos, got = 0;
    bit held = 0;
    int held_idx = 0;
    while (n < D && (mf[c] != 0 || mt[c] != 0)) begin
      exp_idx[n] = c; n++; c = dec(c);
    end
    walk_start_i = 1; step(); walk_start_i = 0;
    for (int k = 0; k < 4 * D + 8 && !walk_done_o; k++) begin
      rec_ready_i = stall ? k[0] : 1'b1; #1;
      if (held) begin
        chk(rec_valid_o && int'(rec_idx_o) == held_idx, "R9", int'(rec_idx_o), held_idx);
      end
      held = rec_valid_o && !rec_ready_i;
      held_idx = int'(rec_idx_o);
      if (rec_valid_o && rec_ready_i) begin
        if (got < n) begin
          chk(int'(rec_idx_o) == exp_idx[got] && int'(rec_from_o) == mf[exp_idx[got]]
              && int'(rec_to_o) == mt[exp_idx[got]], req, int'(rec_idx_o), exp_idx[got]);
        end else begin
          chk(1'b0, req, int'(rec_idx_o), -1);
        end
        got++;
      end
      step();
    end
    rec_ready_i = 1;
    chk(walk_done_o == 1'b1, req, int'(walk_done_o), 1);
    chk(int'(walk_count_o) == n && got == n, req, int'(walk_count_o), n);
  endtask

  task automatic t_reset();
    m_clear(0);
    check_state("R1");
    chk(!rec_valid_o && !walk_done_o, "R1", int'({rec_valid_o, walk_done_o}), 0);
  endtask

  task automatic t_calls();
    for (int i = 1; i <= 3; i++) begin
      ev(1, 0, 'h1000 + i, 'h2000 + i); m_call('h1000 + i, 'h2000 + i);
    end
    check_state("R2");
    run_walk("R7", 0);
  endtask

  task automatic t_rets();
    ev(0, 1, 0, 0); m_ret();
    check_state("R3");
    ev(0, 1, 0, 0); m_ret();
    ev(0, 1, 0, 0); m_ret();
    ev(0, 1, 0, 0); m_ret();   // slot 0 already empty: pointer wraps to 7
    chk(int'(tos_o) == D - 1, "R3", int'(tos_o), D - 1);
    check_state("R3");
  endtask

  task automatic t_clear();
    ev(1, 0, 'h1111, 'h2222); m_call('h1111, 'h2222);
    walk_start_i = 1; rec_ready_i = 0; step(); walk_start_i = 0;
    clr_i = 1; ev_call_i = 1; ev_from_i = 'h3333; ev_to_i = 'h4444; step();
    clr_i = 0; ev_call_i = 0; rec_ready_i = 1; m_clear(0);
    chk(!rec_valid_o && !walk_done_o, "R4", int'({rec_valid_o, walk_done_o}), 0);
    check_state("R4");
  endtask

  task automatic t_overflow();
    for (int i = 1; i <= 11; i++) begin
      ev(1, 0, 'h0100 + i, 'h0200 + i); m_call('h0100 + i, 'h0200 + i);
    end
    check_state("R6");
    run_walk("R8", 0);
    ev(0, 1, 0, 0); m_ret();
    ev(0, 1, 0, 0); m_ret();
    check_state("R6");
    run_walk("R6", 1);
  endtask

  task automatic t_order();
    clr_i = 1; step(); clr_i = 0; m_clear(0);
    ev(1, 1, 'h0a0a, 'h0b0b); m_call('h0a0a, 'h0b0b);
    check_state("R5");                       // CALL done, RET deferred
    ev(1, 1, 'h0c0c, 'h0d0d); m_ret();       // deferred RET runs, CALL deferred, RET dropped
    check_state("R5");
    step(); m_call('h0c0c, 'h0d0d);
    check_state("R5");
    step();
    check_state("R5");
  endtask

  task automatic t_restore();
    ctx_load_i = 1; ctx_tos_i = 3'd5; ev_call_i = 1; ev_from_i = 'h7777; ev_to_i = 'h7777;
    step(); ctx_load_i = 0; m_clear(5);
    check_state("R10");
    ctx_we_i = 1; ctx_idx_i = 3'd5; ctx_from_i = 'h5005; ctx_to_i = 'h6005; step();
    mf[5] = 'h5005; mt[5] = 'h6005;
    ctx_idx_i = 3'd4; ctx_from_i = 'h5004; ctx_to_i = 'h6004; step();
    mf[4] = 'h5004; mt[4] = 'h6004;
    ctx_we_i = 0; ev_call_i = 0;
    check_state("R11");
    run_walk("R11", 1);
    ev(1, 0, 'h0909, 'h0808); m_call('h0909, 'h0808);
    check_state("R12");
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_calls();
    t_rets();
    t_clear();
    t_overflow();
    t_order();
    t_restore();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule